// File: doc/BRIEF.md
# Supervisor Reset Pulse Generator

This block produces the processor reset for a supply supervisor. Two flags come in from the analog side: a supply-low flag and a flag saying the supply has fallen below the backup source. A single-cycle watchdog-timeout strobe also comes in. The outputs are an active-low reset and its active-high complement. While either supply flag is set, reset is asserted in the same cycle, through a combinational path, with no wait for a clock edge.

When the supply flags clear, reset is not released at once. It is stretched for a fixed number of pulses on a tick-enable input. That input is the divided timebase, from either an internal oscillator or an external clock. The default is 200 ticks, which gives 200 ms at a nominal 1 kHz tick. A watchdog timeout starts the same full-length stretch. A synchronous initialisation input puts the block into a stretch that begins from zero, so the first release after start-up also waits for a complete active time.

The control is a three-state machine. HOLD means a supply fault is present. STRETCH means reset is being timed. RUN means reset is released. The named transitions are:
- fault_enter: any state goes to HOLD while a fault flag is set.
- fault_clear: HOLD goes to STRETCH when the flags clear.
- stretch_done: STRETCH goes to RUN on the final counted tick.
- wdog_fire: RUN goes to STRETCH on a watchdog strobe.
- wdog_restart: STRETCH stays in STRETCH with the count cleared on a watchdog strobe.
- init_load: any state goes to STRETCH with the count cleared while the initialisation input is high.

Top module: `suprst_pulse_gen`

## Requirements
- R1: While `line_low` is 1, `sys_rst_n` is 0 in the same cycle, with no clock edge needed.
- R2: While `on_battery` is 1, `sys_rst_n` is 0 in the same cycle, with no clock edge needed.
- R3: After both fault flags are 0, `sys_rst_n` stays 0 until ACT_TICKS cycles with `tick_en`=1 have been sampled in STRETCH. It becomes 1 after the clock edge that samples the ACT_TICKS-th such tick.
- R4: A one-cycle `wdog_expire`=1 while reset is released drives `sys_rst_n` to 0 after the next clock edge. Reset then stays low for ACT_TICKS ticks.
- R5: `sys_rst` is always the logical inverse of `sys_rst_n`.
- R6: A fault flag that rises during the stretch clears the tick count. After the flag clears again, a full ACT_TICKS ticks are needed before release.
- R7: A `wdog_expire` strobe during the stretch restarts the count from zero, so a full ACT_TICKS further ticks are needed.
- R8: While `init` is 1, reset is asserted and the count is cleared. After `init` falls, release needs ACT_TICKS ticks.
- R9: When `wdog_expire` and the final tick arrive in the same cycle, the strobe wins: reset stays asserted and the count restarts from zero.
- R10: While released with no fault and no strobe, `tick_en` pulses leave `sys_rst_n` at 1.
- R11: The stretch count never exceeds ACT_TICKS-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| init | input | 1 | Synchronous initialisation, active high |
| line_low | input | 1 | Supply below reset threshold, active high |
| on_battery | input | 1 | Supply below backup source, active high |
| wdog_expire | input | 1 | One-cycle watchdog timeout strobe |
| tick_en | input | 1 | Timebase tick, one cycle wide per tick |
| sys_rst_n | output | 1 | Processor reset, active low |
| sys_rst | output | 1 | Processor reset, active high |

## Verification
The hardest case to reach is the cycle where a watchdog strobe lands on the very tick that would end the stretch. At that edge the counter's terminal condition and the restart compete. The stimulus reaches it by counting exactly ACT_TICKS-1 ticks after a strobe, then raising `tick_en` and `wdog_expire` together for one cycle. It then confirms that a whole new count is needed. A fault flag raised partway through a stretch is produced the same way, by counting part of the ticks first, to show the partial count is discarded.

// File: rtl/suprst_pkg.sv
package suprst_pkg;

    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_STRETCH = 2'd1,
        ST_RUN     = 2'd2
    } rst_state_t;

endpackage

// File: rtl/suprst_fault_merge.sv
module suprst_fault_merge (
    input  logic line_low,
    input  logic on_battery,
    output logic fault
);

    // Either supply condition holds the processor in reset
    always_comb begin
        fault = line_low | on_battery;
    end

endmodule

// File: rtl/suprst_stretch_cnt.sv
module suprst_stretch_cnt #(
    parameter int ACT_TICKS = 200,
    localparam int CW = (ACT_TICKS > 1) ? $clog2(ACT_TICKS) : 1
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt,
    output logic          last
);

    localparam logic [CW-1:0] LAST_VAL = CW'(ACT_TICKS - 1);

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt <= '0;
        end else if (inc && (cnt != LAST_VAL)) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        last = (cnt == LAST_VAL);
    end

endmodule

// File: rtl/suprst_fsm.sv
module suprst_fsm
    import suprst_pkg::*;
(
    input  logic       clk,
    input  logic       init,
    input  logic       fault,
    input  logic       wdog_expire,
    input  logic       tick_en,
    input  logic       cnt_last,
    output rst_state_t state,
    output logic       cnt_clr,
    output logic       cnt_inc,
    output logic       rst_active
);

    rst_state_t state_nx;

    // State register
    always_ff @(posedge clk) begin
        if (init) begin
            state <= ST_STRETCH;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        if (fault) begin
            state_nx = ST_HOLD;                      // fault_enter
        end else begin
            unique case (state)
                ST_HOLD: begin
                    state_nx = ST_STRETCH;           // fault_clear
                end
                ST_STRETCH: begin
                    if (wdog_expire) begin
                        state_nx = ST_STRETCH;       // wdog_restart
                    end else if (tick_en && cnt_last) begin
                        state_nx = ST_RUN;           // stretch_done
                    end
                end
                ST_RUN: begin
                    if (wdog_expire) begin
                        state_nx = ST_STRETCH;       // wdog_fire
                    end
                end
                default: state_nx = ST_HOLD;
            endcase
        end
    end

    // Outputs
    always_comb begin
        cnt_inc    = 1'b0;
        cnt_clr    = 1'b1;
        rst_active = 1'b1;
        unique case (state)
            ST_HOLD: begin
                cnt_clr = 1'b1;
            end
            ST_STRETCH: begin
                cnt_clr = init | fault | wdog_expire | (tick_en & cnt_last);
                cnt_inc = tick_en;
            end
            ST_RUN: begin
                cnt_clr    = 1'b1;
                rst_active = fault;
            end
            default: begin
                cnt_clr = 1'b1;
            end
        endcase
        if (fault) begin
            rst_active = 1'b1;
        end
    end

endmodule

// File: rtl/suprst_pulse_gen.sv
module suprst_pulse_gen
    import suprst_pkg::*;
#(
    parameter int ACT_TICKS = 200,
    localparam int CW = (ACT_TICKS > 1) ? $clog2(ACT_TICKS) : 1
) (
    input  logic clk,
    input  logic init,
    input  logic line_low,
    input  logic on_battery,
    input  logic wdog_expire,
    input  logic tick_en,
    output logic sys_rst_n,
    output logic sys_rst
);

    logic          fault;
    logic          cnt_clr;
    logic          cnt_inc;
    logic          cnt_last;
    logic          rst_active;
    logic [CW-1:0] stretch_cnt;
    rst_state_t    state;

    suprst_fault_merge u_fault (
        .line_low   (line_low),
        .on_battery (on_battery),
        .fault      (fault)
    );

    suprst_fsm u_fsm (
        .clk         (clk),
        .init        (init),
        .fault       (fault),
        .wdog_expire (wdog_expire),
        .tick_en     (tick_en),
        .cnt_last    (cnt_last),
        .state       (state),
        .cnt_clr     (cnt_clr),
        .cnt_inc     (cnt_inc),
        .rst_active  (rst_active)
    );

    suprst_stretch_cnt #(
        .ACT_TICKS (ACT_TICKS)
    ) u_cnt (
        .clk  (clk),
        .clr  (cnt_clr),
        .inc  (cnt_inc),
        .cnt  (stretch_cnt),
        .last (cnt_last)
    );

    always_comb begin
        sys_rst_n = ~rst_active;
        sys_rst   = rst_active;
    end

endmodule

// File: rtl/suprst_pulse_gen_chk.sv
module suprst_pulse_gen_chk #(
    parameter int ACT_TICKS = 200,
    localparam int CW = (ACT_TICKS > 1) ? $clog2(ACT_TICKS) : 1
) (
    input logic          clk,
    input logic          init,
    input logic          line_low,
    input logic          on_battery,
    input logic          wdog_expire,
    input logic          tick_en,
    input logic          sys_rst_n,
    input logic          sys_rst,
    input logic [CW-1:0] stretch_cnt
);

    // R1
    a_r1_lowline_asserts: assert property (@(posedge clk) disable iff (init)
        line_low |-> !sys_rst_n);

    // R2
    a_r2_battery_asserts: assert property (@(posedge clk) disable iff (init)
        on_battery |-> !sys_rst_n);

    // R4
    a_r4_wdog_fires: assert property (@(posedge clk) disable iff (init)
        wdog_expire |=> !sys_rst_n);

    // R3
    a_r3_release_on_tick: assert property (@(posedge clk) disable iff (init)
        $rose(sys_rst_n) |-> $past(tick_en));

    // R5
    a_r5_complement: assert property (@(posedge clk) disable iff (init)
        sys_rst == !sys_rst_n);

    // R11
    a_r11_cnt_bound: assert property (@(posedge clk) disable iff (init)
        stretch_cnt <= CW'(ACT_TICKS - 1));

endmodule

bind suprst_pulse_gen suprst_pulse_gen_chk #(
    .ACT_TICKS (ACT_TICKS)
) u_chk (
    .clk         (clk),
    .init        (init),
    .line_low    (line_low),
    .on_battery  (on_battery),
    .wdog_expire (wdog_expire),
    .tick_en     (tick_en),
    .sys_rst_n   (sys_rst_n),
    .sys_rst     (sys_rst),
    .stretch_cnt (stretch_cnt)
);

// File: tb/suprst_pulse_gen_tb.sv
module suprst_pulse_gen_tb;

    localparam int ACT = 6;

    logic clk = 1'b0;
    logic init = 1'b1;
    logic line_low = 1'b0;
    logic on_battery = 1'b0;
    logic wdog_expire = 1'b0;
    logic tick_en = 1'b0;
    logic sys_rst_n;
    logic sys_rst;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    suprst_pulse_gen #(.ACT_TICKS(ACT)) u_dut (
        .clk         (clk),
        .init        (init),
        .line_low    (line_low),
        .on_battery  (on_battery),
        .wdog_expire (wdog_expire),
        .tick_en     (tick_en),
        .sys_rst_n   (sys_rst_n),
        .sys_rst     (sys_rst)
    );

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_rst(string req, logic exp_n);
        check(req, sys_rst_n, exp_n);
        check({req, "/R5"}, sys_rst, ~exp_n);
    endtask

    // Called at a negedge; each tick is high for one posedge
    task automatic do_ticks(int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic wdog_pulse();
        wdog_expire = 1'b1;
        @(negedge clk);
        wdog_expire = 1'b0;
    endtask

    task automatic test_init();
        repeat (3) @(negedge clk);
        check_rst("R8 reset state", 1'b0);
        init = 1'b0;
        @(negedge clk);
        do_ticks(ACT - 1);
        check_rst("R8 before full count", 1'b0);
        do_ticks(1);
        check_rst("R8 released", 1'b1);
    endtask

    task automatic test_lowline();
        line_low = 1'b1;
        #1;
        check_rst("R1 immediate", 1'b0);
        @(negedge clk);
        do_ticks(ACT + 2);
        check_rst("R1 held", 1'b0);
        line_low = 1'b0;
        @(negedge clk);
        do_ticks(ACT - 1);
        check_rst("R3 stretch", 1'b0);
        do_ticks(1);
        check_rst("R3 release", 1'b1);
    endtask

    task automatic test_battery();
        on_battery = 1'b1;
        #1;
        check_rst("R2 immediate", 1'b0);
        @(negedge clk);
        on_battery = 1'b0;
        @(negedge clk);
        do_ticks(ACT - 1);
        check_rst("R2 stretch", 1'b0);
        do_ticks(1);
        check_rst("R2 release", 1'b1);
    endtask

    task automatic test_wdog();
        wdog_pulse();
        check_rst("R4 fires", 1'b0);
        do_ticks(ACT - 1);
        check_rst("R4 full length", 1'b0);
        do_ticks(1);
        check_rst("R4 release", 1'b1);
    endtask

    task automatic test_fault_mid();
        line_low = 1'b1;
        @(negedge clk);
        line_low = 1'b0;
        @(negedge clk);
        do_ticks(3);
        on_battery = 1'b1;
        #1;
        check_rst("R6 fault mid", 1'b0);
        @(negedge clk);
        on_battery = 1'b0;
        @(negedge clk);
        do_ticks(ACT - 1);
        check_rst("R6 count cleared", 1'b0);
        do_ticks(1);
        check_rst("R6 release", 1'b1);
    endtask

    task automatic test_wdog_mid();
        wdog_pulse();
        do_ticks(ACT - 2);
        wdog_pulse();
        do_ticks(ACT - 1);
        check_rst("R7 restart", 1'b0);
        do_ticks(1);
        check_rst("R7 release", 1'b1);
    endtask

    task automatic test_wdog_last();
        wdog_pulse();
        do_ticks(ACT - 1);
        tick_en = 1'b1;
        wdog_expire = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
        wdog_expire = 1'b0;
        check_rst("R9 strobe wins", 1'b0);
        do_ticks(ACT - 1);
        check_rst("R9 full recount", 1'b0);
        do_ticks(1);
        check_rst("R9 release", 1'b1);
    endtask

    task automatic test_idle_ticks();
        do_ticks(ACT * 3);
        check_rst("R10 ticks ignored", 1'b1);
    endtask

    initial begin
        test_init();
        test_lowline();
        test_battery();
        test_wdog();
        test_fault_mid();
        test_wdog_mid();
        test_wdog_last();
        test_idle_ticks();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog timeout actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule